// File: doc/BRIEF.md
# Dual-Compare Up/Down Counter with Preload

This block is one counter channel. It holds a 16-bit up/down counter, two compare registers and two load registers. While counting is enabled, the counter steps by one each clock in the direction given by `cnt_up`. Each compare register is checked against the counter only while the counter moves in the direction that the compare-mode field assigns to it. A hit produces a one-clock pulse on that compare's match output.

Each compare register has its own 3-bit load code. The code chooses the match that triggers a reload, and it chooses the value that is loaded. The target is either that compare register or the counter itself. This lets software build chains of compare values, or make the counter jump on a match, without servicing each event. All registers are written through a plain address/data write port. The block carries no data stream, so it has no valid/ready handshake. A write happens on the edge where `wr_en` is high and cannot be stalled.

Top module: `dual_cmp_counter`

## Requirements
- R1: Asynchronous active-low reset clears the counter, both compare registers, both load registers and the control word, so both load codes and the mode are zero. Both match outputs are low during reset.
- R2: With `cnt_en` high and no write or load to the counter on that edge, the counter goes up by 1 when `cnt_up`=1 and down by 1 when `cnt_up`=0, wrapping modulo 2^WIDTH. With `cnt_en` low it holds.
- R3: A write with `wr_en`=1 updates, on that edge, the register chosen by `wr_addr`: 0 counter, 1 compare A, 2 compare B, 3 load A, 4 load B, 5 control. The control word carries load code A in bits [2:0], load code B in bits [5:3] and the mode in bits [7:6]. A write beats any reload or count step of the same register on the same edge.
- R4: A match output is high for exactly the cycle after a cycle in which `cnt_en` was high, the direction qualified that compare, and the counter equalled its compare register.
- R5: Mode bit 6 selects the direction for compare A and mode bit 7 selects it for compare B (0 = checked while counting up, 1 = checked while counting down). Mode 00 checks both up, 01 checks A down and B up, 10 checks A up and B down, 11 checks both down.
- R6: Load codes 010 and 011 load the code's own compare register from load A, on a match of compare A or compare B respectively. Codes 100 and 101 do the same from load B. The load happens on the edge that ends the cycle in which the match output is high.
- R7: Code 110 or 111 in load code A loads the counter from load A, on a match of compare A or compare B respectively. In load code B the same codes load the counter from load B. The counter load happens at the same point as in R6 and replaces that edge's count step.
- R8: When both load codes load the counter on the same edge, the value from load A wins.
- R9: Codes 000 and 001 never reload anything.
- R10: A compare that is not qualified for the current direction produces no match and so triggers no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | WIDTH | Write data |
| match_a | output | 1 | Compare A match pulse |
| match_b | output | 1 | Compare B match pulse |
| count | output | WIDTH | Current counter value |

## Verification
A corrupted compare register or a wrong load code does not show at once. It becomes visible as a missing, extra or misplaced match pulse the next time the counter sweeps through the value, which can be many cycles later. A wrong counter reload shows on `count` on the very next edge after the match pulse. A bad direction qualifier shows as a pulse one cycle after the counter passes a value in the wrong direction. For these reasons the bench compares `count` and both match outputs against a model on every cycle, using small register values that make sweeps and matches frequent.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    ADDR_COUNT = 3'd0,
    ADDR_CMPA  = 3'd1,
    ADDR_CMPB  = 3'd2,
    ADDR_LDA   = 3'd3,
    ADDR_LDB   = 3'd4,
    ADDR_CTRL  = 3'd5
  } reg_addr_e;

  // upper two bits of a load code
  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_FROMA = 2'b01,
    KIND_FROMB = 2'b10,
    KIND_COUNT = 2'b11
  } ld_kind_e;

  typedef struct packed {
    logic [1:0] mode;   // [7:6]
    logic [2:0] code_b; // [5:3]
    logic [2:0] code_a; // [2:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dcc_counter.sv
module dcc_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             up,
  input  logic             wr,
  input  logic [WIDTH-1:0] wr_val,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  output logic [WIDTH-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (wr)  value <= wr_val;
    else if (ld)  value <= ld_val;
    else if (en)  value <= up ? value + WIDTH'(1) : value - WIDTH'(1);
  end
endmodule

// File: rtl/dcc_cmp_unit.sv
module dcc_cmp_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             up,
  input  logic             on_down,
  input  logic [WIDTH-1:0] count,
  input  logic             wr,
  input  logic             ld,
  input  logic [WIDTH-1:0] new_val,
  output logic [WIDTH-1:0] cmp_val,
  output logic             match
);
  logic armed;
  assign armed = en && (up != on_down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '0;
      match   <= 1'b0;
    end else begin
      match <= armed && (count == cmp_val);
      if (wr || ld) cmp_val <= new_val;
    end
  end
endmodule

// File: rtl/dcc_load_dec.sv
module dcc_load_dec #(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       code,
  input  logic             hit_a,
  input  logic             hit_b,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [WIDTH-1:0] ctr_src,
  output logic             cmp_ld,
  output logic             ctr_ld,
  output logic [WIDTH-1:0] cmp_src,
  output logic [WIDTH-1:0] ctr_val
);
  import dcc_pkg::*;
  ld_kind_e kind;
  logic     fire;

  assign kind    = ld_kind_e'(code[2:1]);
  assign fire    = code[0] ? hit_b : hit_a;
  assign ctr_val = ctr_src;

  always_comb begin
    cmp_ld  = 1'b0;
    ctr_ld  = 1'b0;
    cmp_src = src_a;
    unique case (kind)
      KIND_FROMA: cmp_ld = fire;
      KIND_FROMB: begin
        cmp_ld  = fire;
        cmp_src = src_b;
      end
      KIND_COUNT: ctr_ld = fire;
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_cmp_counter.sv
module dual_cmp_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic             match_a,
  output logic             match_b,
  output logic [WIDTH-1:0] count
);
  import dcc_pkg::*;
  localparam int NCMP = 2;

  ctrl_t            ctrl;
  logic [WIDTH-1:0] load_a, load_b;
  logic [WIDTH-1:0] cmp_val [NCMP];
  logic [NCMP-1:0]  hit;
  logic [NCMP-1:0]  cmp_ld, ctr_ld, cmp_wr;
  logic [WIDTH-1:0] cmp_src [NCMP];
  logic [WIDTH-1:0] ctr_val [NCMP];
  logic [WIDTH-1:0] ctr_next;
  logic             ctr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      load_a <= '0;
      load_b <= '0;
    end else if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        ADDR_LDA:  load_a <= wr_data;
        ADDR_LDB:  load_b <= wr_data;
        ADDR_CTRL: ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  assign ctr_wr = wr_en && (reg_addr_e'(wr_addr) == ADDR_COUNT);

  for (genvar i = 0; i < NCMP; i++) begin : g_ch
    logic [2:0] code;
    logic [WIDTH-1:0] nv;
    assign code      = (i == 0) ? ctrl.code_a : ctrl.code_b;
    assign cmp_wr[i] = wr_en && (wr_addr == 3'(i + 1));
    assign nv        = cmp_wr[i] ? wr_data : cmp_src[i];

    dcc_load_dec #(.WIDTH(WIDTH)) u_dec (
      .code    (code),
      .hit_a   (hit[0]),
      .hit_b   (hit[1]),
      .src_a   (load_a),
      .src_b   (load_b),
      .ctr_src ((i == 0) ? load_a : load_b),
      .cmp_ld  (cmp_ld[i]),
      .ctr_ld  (ctr_ld[i]),
      .cmp_src (cmp_src[i]),
      .ctr_val (ctr_val[i])
    );

    dcc_cmp_unit #(.WIDTH(WIDTH)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cnt_en),
      .up      (cnt_up),
      .on_down (ctrl.mode[i]),
      .count   (count),
      .wr      (cmp_wr[i]),
      .ld      (cmp_ld[i]),
      .new_val (nv),
      .cmp_val (cmp_val[i]),
      .match   (hit[i])
    );
  end

  // control A has priority for counter loads
  assign ctr_next = ctr_ld[0] ? ctr_val[0] : ctr_val[1];

  dcc_counter #(.WIDTH(WIDTH)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cnt_en),
    .up     (cnt_up),
    .wr     (ctr_wr),
    .wr_val (wr_data),
    .ld     (|ctr_ld),
    .ld_val (ctr_next),
    .value  (count)
  );

  assign match_a = hit[0];
  assign match_b = hit[1];
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             cnt_up,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [WIDTH-1:0] count,
  input logic             match_a,
  input logic             match_b,
  input logic [WIDTH-1:0] cmp_a,
  input logic [WIDTH-1:0] cmp_b,
  input logic [WIDTH-1:0] load_a,
  input logic [7:0]       ctrl_bits,
  input logic [1:0]       ctr_ld
);
  // R4 R5 R10
  match_a_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |-> ($past(cnt_en) && ($past(count) == $past(cmp_a)) &&
                 ($past(cnt_up) != $past(ctrl_bits[6]))));

  // R4 R5 R10
  match_b_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_b |-> ($past(cnt_en) && ($past(count) == $past(cmp_b)) &&
                 ($past(cnt_up) != $past(ctrl_bits[7]))));

  // R9
  cmp_a_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en && wr_addr == 3'd1) && $past(ctrl_bits[2:1] == 2'b00))
      |-> (cmp_a == $past(cmp_a)));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_en) && !$past(wr_en && wr_addr == 3'd0) && !$past(|ctr_ld))
      |-> (count == ($past(cnt_up) ? $past(count) + WIDTH'(1)
                                   : $past(count) - WIDTH'(1))));

  // R8
  ctr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctr_ld[0]) && !$past(wr_en && wr_addr == 3'd0))
      |-> (count == $past(load_a)));
endmodule

bind dual_cmp_counter dcc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .cnt_up    (cnt_up),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .count     (count),
  .match_a   (match_a),
  .match_b   (match_b),
  .cmp_a     (cmp_val[0]),
  .cmp_b     (cmp_val[1]),
  .load_a    (load_a),
  .ctrl_bits (ctrl),
  .ctr_ld    (ctr_ld)
);

// File: tb/sim_dual_cmp_counter.sv
module sim_dual_cmp_counter;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, cnt_up = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic match_a, match_b;
  logic [W-1:0] count;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  dual_cmp_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .match_a(match_a), .match_b(match_b), .count(count)
  );

  // behavioural reference model
  int unsigned m_cnt = 0, m_ca = 0, m_cb = 0, m_la = 0, m_lb = 0;
  int unsigned m_ka = 0, m_kb = 0, m_mode = 0;
  bit m_ma = 0, m_mb = 0;
  localparam int unsigned MOD = 1 << W;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ca = 0; m_cb = 0; m_la = 0; m_lb = 0;
      m_ka = 0; m_kb = 0; m_mode = 0; m_ma = 0; m_mb = 0;
    end else begin
      int unsigned n_cnt, n_ca, n_cb;
      bit qa, qb, a_dn, b_dn;
      a_dn = (m_mode & 1) != 0;
      b_dn = (m_mode & 2) != 0;
      qa = cnt_en && (cnt_up ? !a_dn : a_dn) && (m_cnt == m_ca);
      qb = cnt_en && (cnt_up ? !b_dn : b_dn) && (m_cnt == m_cb);
      n_ca = m_ca; n_cb = m_cb; n_cnt = m_cnt;
      if (cnt_en) n_cnt = cnt_up ? (m_cnt + 1) % MOD : (m_cnt + MOD - 1) % MOD;
      case (m_kb)
        2: if (m_ma) n_cb = m_la;
        3: if (m_mb) n_cb = m_la;
        4: if (m_ma) n_cb = m_lb;
        5: if (m_mb) n_cb = m_lb;
        6: if (m_ma) n_cnt = m_lb;
        7: if (m_mb) n_cnt = m_lb;
        default: ;
      endcase
      case (m_ka)
        2: if (m_ma) n_ca = m_la;
        3: if (m_mb) n_ca = m_la;
        4: if (m_ma) n_ca = m_lb;
        5: if (m_mb) n_ca = m_lb;
        6: if (m_ma) n_cnt = m_la;
        7: if (m_mb) n_cnt = m_la;
        default: ;
      endcase
      if (wr_en) begin
        case (wr_addr)
          0: n_cnt = wr_data;
          1: n_ca = wr_data;
          2: n_cb = wr_data;
          3: m_la = wr_data;
          4: m_lb = wr_data;
          5: begin
            m_ka = wr_data & 7; m_kb = (wr_data >> 3) & 7; m_mode = (wr_data >> 6) & 3;
          end
          default: ;
        endcase
      end
      m_cnt = n_cnt; m_ca = n_ca; m_cb = n_cb; m_ma = qa; m_mb = qb;
    end
  end

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({phase, " count"}, count, m_cnt);
    check({phase, " match_a"}, match_a, m_ma);
    check({phase, " match_b"}, match_b, m_mb);
  end

  task automatic wr(input int a, input int unsigned d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int unsigned ctl, input int unsigned c, input int unsigned ca,
                       input int unsigned cb, input int unsigned la, input int unsigned lb);
    cnt_en = 1'b0;
    wr(5, ctl); wr(1, ca); wr(2, cb); wr(3, la); wr(4, lb); wr(0, c);
  endtask

  task automatic run(input bit up, input int n);
    cnt_up = up; cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1 count", count, 0);
    check("R1 match_a", match_a, 0);
    check("R1 match_b", match_b, 0);
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R3";
    wr(0, 10);
    check("R3 count write", count, 10);

    phase = "R2";
    run(1, 5);
    check("R2 up", count, 15);
    run(0, 7);
    check("R2 down", count, 8);
    wr(0, 0); run(0, 1);
    check("R2 wrap", count, MOD - 1);

    phase = "R5";
    setup(8'h80, 8, 40, 5, 0, 0);   // mode 10: B checked while down
    run(0, 4);
    check("R5 match_b down", match_b, 1);
    setup(8'h40, 0, 3, 50, 0, 0);   // mode 01: A checked down, so up is blind
    run(1, 4);
    check("R5 match_a blind up", match_a, 0);

    phase = "R6";
    setup(8'h02, 0, 3, 60, 7, 0);   // code A 010
    run(1, 8);
    check("R6 reload A from load A", match_a, 1);
    setup(8'h28, 0, 60, 2, 0, 9);   // code B 101
    run(1, 10);
    check("R6 reload B from load B", match_b, 1);
    setup(8'h1B, 0, 2, 5, 6, 12);   // A 011, B 011
    run(1, 20);

    phase = "R7";
    setup(8'h06, 0, 3, 60, 100, 200);  // A 110
    run(1, 5);
    check("R7 counter from load A", count, 100);
    setup(8'h38, 0, 60, 4, 100, 200);  // B 111
    run(1, 6);
    check("R7 counter from load B", count, 200);

    phase = "R8";
    setup(8'h36, 0, 3, 60, 100, 200);  // both 110
    run(1, 5);
    check("R8 load A wins", count, 100);

    phase = "R9";
    setup(8'h09, 0, 3, 3, 100, 200);   // both 001
    run(1, 6);
    check("R9 reserved no load", count, 6);
    wr(0, 0); run(1, 4);
    check("R9 compare kept", match_a, 1);

    phase = "R10";
    setup(8'h46, 0, 3, 60, 100, 200);  // A checked down, code 110
    run(1, 5);
    check("R10 no match no load", count, 5);

    phase = "R4";
    setup(8'h00, 0, 2, 2, 0, 0);
    cnt_up = 1'b1; cnt_en = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      cnt_en = ($urandom_range(0, 7) != 0);
      cnt_up = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 9) == 0) begin
        wr_en = 1'b1;
        wr_addr = 3'($urandom_range(0, 5));
        wr_data = (wr_addr == 3'd5) ? W'($urandom_range(0, 255)) : W'($urandom_range(0, 15));
      end else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0; cnt_en = 1'b0;
    @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule